// File: doc/BRIEF.md
# Stack Pointer Unit with Limit Check

This block holds the processor's dedicated software stack pointer and a separate stack-limit register. Decoded strobes from the instruction pipeline tell it to push, to pop, or to load the pointer or the limit directly from a write-data bus. A push reads the access address from the current pointer and then moves the pointer up. A pop moves the pointer down first and uses the lowered value as its access address. A double-width strobe makes either operation move by two words, as a 24-bit return address needs.

Both the pointer and the limit are kept word aligned: bit 0 of each is held at zero. Once software has loaded the limit, any push whose resulting pointer would lie above the limit raises a one-cycle error pulse. The pointer still takes its new value, so the trap logic that follows can see where the stack went. The unit does not vector the trap and does not drive memory. It only supplies the pointer, the address for the current access, and the error pulse. Neither register takes part in any shadow save or restore.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0200, the error output is low, and the limit check is disarmed (the limit reads as 0x0000).
- R2: A single-word push drives the access address with the current pointer in the same cycle. The pointer reads 2 higher from the next cycle on.
- R3: A push with the double strobe high drives the access address with the current pointer. The pointer reads 4 higher from the next cycle on.
- R4: A pop drives the access address with the pointer minus the step (2, or 4 with the double strobe) in the same cycle. The pointer reads that lowered value from the next cycle on. With no pop, the access address equals the pointer.
- R5: A direct pointer write loads the write data with bit 0 cleared, visible the next cycle. In the same cycle it overrides any push or pop, and that push raises no error.
- R6: A limit write stores the write data with bit 0 cleared and arms the check from the next cycle on. An odd limit therefore acts exactly as the even value below it.
- R7: While the check is armed, a push whose new pointer is above the limit drives the error output high for exactly the next cycle, and the pointer is still updated. A carry out of the top pointer bit counts as above the limit. A push that lands exactly on the limit, and any pop, raises no error.
- R8: While the check is disarmed, no push raises an error, including one that wraps the pointer past its top.
- R9: When push and pop are strobed together without a direct write, the push is performed and the pop is ignored.
- R10: Bit 0 of the pointer output is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| dbl_i | input | 1 | Double-word step for push or pop |
| sp_wr_i | input | 1 | Direct write of the pointer |
| lim_wr_i | input | 1 | Write of the limit register |
| wr_data_i | input | 16 | Data for either direct write |
| sp_o | output | 16 | Current stack pointer |
| acc_addr_o | output | 16 | Address of this cycle's stack access |
| stk_err_o | output | 1 | One-cycle stack-limit error pulse |

## Verification
The access address is combinational, so the bench checks it in the same cycle the strobe is driven, shortly after the inputs settle. The pointer and the error pulse come from registers: each is due one clock edge after its strobe. Every driven cycle places its expected pointer and error value in a queue. A monitor removes one entry just after each rising edge and compares it with the outputs, so every comparison happens exactly one register stage after its stimulus.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned WORD_BYTES = 2;

  typedef enum logic [1:0] {
    SP_HOLD  = 2'd0,
    SP_UP    = 2'd1,
    SP_DOWN  = 2'd2,
    SP_LOAD  = 2'd3
  } sp_action_e;

  // Step in bytes for a single or a double-word stack operation.
  function automatic int unsigned step_bytes(input logic dbl);
    return dbl ? 2 * WORD_BYTES : WORD_BYTES;
  endfunction
endpackage

// File: rtl/sp_adjust.sv
module sp_adjust
  import sp_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] sp,
  input  logic          push,
  input  logic          pop,
  input  logic          dbl,
  input  logic          load,
  output sp_action_e    action,
  output logic [AW-1:0] sp_next_adj,
  output logic [AW-1:0] addr,
  output logic [AW:0]   up_sum
);
  localparam int unsigned EW = AW + 1;

  logic [AW:0] step_ext;

  always_comb begin
    step_ext = EW'(step_bytes(dbl));
    up_sum   = {1'b0, sp} + step_ext;

    if (load)      action = SP_LOAD;
    else if (push) action = SP_UP;
    else if (pop)  action = SP_DOWN;
    else           action = SP_HOLD;

    case (action)
      SP_UP:   sp_next_adj = up_sum[AW-1:0];
      SP_DOWN: sp_next_adj = sp - step_ext[AW-1:0];
      default: sp_next_adj = sp;
    endcase

    addr = (pop && !push) ? (sp - step_ext[AW-1:0]) : sp;
  end
endmodule

// File: rtl/sp_limit.sv
module sp_limit #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lim_wr,
  input  logic [AW-1:0] wr_data,
  input  logic          push_go,
  input  logic [AW:0]   up_sum,
  output logic          armed,
  output logic          over
);
  logic [AW-1:0] lim_q;

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] v);
    return {v[AW-1:1], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      armed <= 1'b0;
    end else if (lim_wr) begin
      lim_q <= word_align(wr_data);
      armed <= 1'b1;
    end
  end

  assign over = armed && push_go && (up_sum > {1'b0, lim_q});
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          dbl_i,
  input  logic          sp_wr_i,
  input  logic          lim_wr_i,
  input  logic [AW-1:0] wr_data_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] acc_addr_o,
  output logic          stk_err_o
);
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_adj;
  logic [AW:0]   up_sum;
  sp_action_e    action;
  logic          push_go;
  logic          pop_go;
  logic          lim_armed;
  logic          lim_over;
  logic          err_q;

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] v);
    return {v[AW-1:1], 1'b0};
  endfunction

  sp_adjust #(.AW(AW)) u_adjust (
    .sp          (sp_q),
    .push        (push_i),
    .pop         (pop_i),
    .dbl         (dbl_i),
    .load        (sp_wr_i),
    .action      (action),
    .sp_next_adj (sp_adj),
    .addr        (acc_addr_o),
    .up_sum      (up_sum)
  );

  assign push_go = (action == SP_UP);
  assign pop_go  = (action == SP_DOWN);

  sp_limit #(.AW(AW)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .lim_wr  (lim_wr_i),
    .wr_data (wr_data_i),
    .push_go (push_go),
    .up_sum  (up_sum),
    .armed   (lim_armed),
    .over    (lim_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= word_align(SP_INIT);
      err_q <= 1'b0;
    end else begin
      sp_q  <= (action == SP_LOAD) ? word_align(wr_data_i) : word_align(sp_adj);
      err_q <= lim_over;
    end
  end

  assign sp_o      = sp_q;
  assign stk_err_o = err_q;
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sp_wr_i,
  input logic          dbl_i,
  input logic [AW-1:0] wr_data_i,
  input logic [AW-1:0] sp_o,
  input logic          stk_err_o,
  input logic          push_go,
  input logic          pop_go,
  input logic          lim_armed
);
  // R10
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o[0] == 1'b0);

  // R5
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_i |=> sp_o == {$past(wr_data_i[AW-1:1]), 1'b0});

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_go && !dbl_i) |=> sp_o == $past(sp_o) + AW'(2));

  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_go && !dbl_i) |=> sp_o == $past(sp_o) - AW'(2));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_err_o) |-> $past(push_go));

  // R8
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_armed |=> !stk_err_o);
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sp_wr_i   (sp_wr_i),
  .dbl_i     (dbl_i),
  .wr_data_i (wr_data_i),
  .sp_o      (sp_o),
  .stk_err_o (stk_err_o),
  .push_go   (push_go),
  .pop_go    (pop_go),
  .lim_armed (lim_armed)
);

// File: tb/stack_ptr_unit_bench.sv
module stack_ptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_i, pop_i, dbl_i, sp_wr_i, lim_wr_i;
  logic [15:0] wr_data_i;
  logic [15:0] sp_o, acc_addr_o;
  logic        stk_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] sp;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_sp = 16'h0200;
  logic [15:0] m_lim = 16'h0000;
  bit          m_armed = 0;

  always #2 clk = ~clk;

  stack_ptr_unit u_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .dbl_i(dbl_i),
    .sp_wr_i(sp_wr_i), .lim_wr_i(lim_wr_i), .wr_data_i(wr_data_i),
    .sp_o(sp_o), .acc_addr_o(acc_addr_o), .stk_err_o(stk_err_o)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one queued expectation per driven cycle, compared just after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " sp"}, {1'b0, sp_o}, {1'b0, e.sp});
      check({e.tag, " err"}, {16'h0, stk_err_o}, {16'h0, e.err});
    end
  end

  // Driver: applies one cycle of strobes and queues the outcome it predicts.
  task automatic drive(input bit pu, input bit po, input bit db, input bit sw,
                       input bit lw, input logic [15:0] d, input string tag);
    int unsigned step;
    logic [16:0] sum;
    logic [15:0] addr;
    exp_t e;
    @(negedge clk);
    push_i = pu; pop_i = po; dbl_i = db; sp_wr_i = sw; lim_wr_i = lw; wr_data_i = d;
    step = db ? 4 : 2;
    addr = (po && !pu) ? m_sp - 16'(step) : m_sp;
    #0.5;
    check({tag, " addr"}, {1'b0, acc_addr_o}, {1'b0, addr});
    e.err = 1'b0;
    e.tag = tag;
    if (sw) begin
      m_sp = d & 16'hFFFE;
    end else if (pu) begin
      sum = {1'b0, m_sp} + 17'(step);
      e.err = m_armed && (sum > {1'b0, m_lim});
      m_sp = sum[15:0];
    end else if (po) begin
      m_sp = m_sp - 16'(step);
    end
    if (lw) begin
      m_lim = d & 16'hFFFE;
      m_armed = 1;
    end
    e.sp = m_sp;
    sb.push_back(e);
  endtask

  initial begin
    push_i = 0; pop_i = 0; dbl_i = 0; sp_wr_i = 0; lim_wr_i = 0; wr_data_i = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1 sp", {1'b0, sp_o}, 17'h0200);
    check("R1 err", {16'h0, stk_err_o}, 17'h0);
    drive(0, 0, 0, 0, 0, 16'h0, "R1 idle");
    drive(1, 0, 0, 0, 0, 16'h0, "R2 push");
    drive(1, 0, 1, 0, 0, 16'h0, "R3 dbl push");
    drive(0, 1, 0, 0, 0, 16'h0, "R4 pop");
    drive(0, 1, 1, 0, 0, 16'h0, "R4 dbl pop");
    // R8: wrap while disarmed
    drive(0, 0, 0, 1, 0, 16'hFFFE, "R5 load top");
    drive(1, 0, 0, 0, 0, 16'h0, "R8 wrap push");
    drive(1, 0, 1, 0, 0, 16'h0, "R8 push");
    // R5 / R10: odd write
    drive(0, 0, 0, 1, 0, 16'h1235, "R10 odd load");
    drive(1, 0, 0, 1, 0, 16'h0400, "R5 load beats push");
    drive(0, 1, 0, 1, 0, 16'h0500, "R5 load beats pop");
    drive(1, 1, 0, 0, 0, 16'h0, "R9 push+pop");
    // R6 / R7: arm with odd limit 0x0505 (acts as 0x0504)
    drive(0, 0, 0, 0, 1, 16'h0505, "R6 limit write");
    drive(1, 0, 0, 0, 0, 16'h0, "R6 push to limit");
    drive(1, 0, 0, 0, 0, 16'h0, "R7 push over");
    drive(0, 0, 0, 0, 0, 16'h0, "R7 pulse ends");
    drive(1, 0, 1, 0, 0, 16'h0, "R7 dbl over");
    drive(0, 1, 0, 0, 0, 16'h0, "R7 pop no err");
    drive(1, 0, 0, 1, 0, 16'h0600, "R5 load suppresses err");
    // R7: carry counts as above limit
    drive(0, 0, 0, 1, 1, 16'hFFFE, "R7 set top");
    drive(1, 0, 0, 0, 0, 16'h0, "R7 carry push");
    drive(0, 1, 0, 0, 0, 16'h0, "R4 pop wrap");
    drive(0, 0, 0, 0, 0, 16'h0, "R4 idle");
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule